// File: doc/BRIEF.md
# SPI memory-access frame engine

This block is an SPI master that carries out one memory-access frame against the address space of a little-endian DSP sitting behind an SPI slave port. A host hands it a descriptor made of a command code, a 32-bit target address and a byte count. The engine then runs the frame on the four SPI wires. It sends a command byte, the four address bytes, the dummy bytes the command calls for and the data bytes. It then releases chip select and pulses a completion strobe.

Write data is pulled from the host as a byte stream with a ready/valid handshake. Read data is pushed back as a byte stream qualified by a valid strobe. In both directions the engine reverses the order of the bytes inside every data word. The host therefore sees memory in its own byte order, while the wire carries each word most significant byte first. The word size is set by the command. The engine runs exactly one frame per descriptor. Splitting a large transfer into frames is left to the host.

Top module: `spimf_engine`

## Requirements
- R1: Every frame starts with the command byte (0x00 to 0x05, the 3-bit code in the low bits), followed by the 32-bit address with its most significant byte first. Every byte goes out most significant bit first in SPI mode 0: SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R2: The command code is decoded as follows. Bit 0 set means a write, and bit 0 clear means a read. Bits 2:1 select the data word size: 0 gives 2 bytes, 1 gives 4 bytes, and 2 gives 8 bytes (burst). So code 0x0 is read 2-byte, 0x1 is write 2-byte, 0x2 is read 4-byte, 0x3 is write 4-byte, 0x4 is read burst and 0x5 is write burst.
- R3: A read frame sends four 0x00 dummy bytes after the address, then clocks in the data bytes while sending 0x00 on MOSI.
- R4: A write frame sends the data bytes right after the address, then one trailing 0x00 dummy byte, and nothing more.
- R5: Within every data word of W bytes, wire data byte i of word w is host byte w*W + W-1-i. This holds both for write data taken from the host stream and for read data given back to it.
- R6: A 2-byte or 4-byte command carries exactly one data word, whatever the byte count in the descriptor.
- R7: A burst carries floor(count/8) words of 8 bytes, limited to the range 1 to 30 words. The low three bits of the count are ignored, a count below 8 gives 8 bytes, and a count above 240 gives 240 bytes.
- R8: CS_N is low for the whole frame. It then stays high for at least one SCLK period (two system clocks at the bench rate) before the next frame begins. SCLK stays low whenever CS_N is high.
- R9: `done` is a one-cycle pulse that is raised only while CS_N is high, once per frame. `desc_ready` is high only when the engine is idle. A descriptor that is presented while a frame runs is not taken and does not change that frame.
- R10: Write bytes are consumed only on cycles where `wr_valid` and `wr_ready` are both high, and the engine waits for any number of idle cycles on the source. Read bytes are presented one per `rd_valid` cycle in host order, exactly the number of bytes in the frame.
- R11: After reset, CS_N is high, SCLK is low, `desc_ready` is high, and `done`, `rd_valid` and `wr_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor taken on this cycle if valid |
| desc_cmd | input | 3 | Command code |
| desc_addr | input | 32 | Target start address |
| desc_len | input | LEN_W | Byte count (burst commands only) |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Engine accepts a write byte |
| wr_data | input | 8 | Write byte in host order |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte in host order |
| done | output | 1 | Frame complete pulse |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Master-out serial data |
| spi_miso | input | 1 | Master-in serial data |

## Verification
A wrong state in the sequencer would show up on the wire within the same frame. The frame would be too long or too short, a dummy byte would be missing or sit in the wrong place, or a word would come out with its bytes in the wrong order. A slave model captures every MOSI bit, so any of these faults shows up when that frame is checked. A wrong word-buffer index or a wrong remaining-word count appears as swapped or missing bytes on the read stream, or as write bytes pulled in the wrong number. The chip-select gap and the position of the completion pulse are checked on every frame boundary, and stray descriptors offered during a frame are checked by confirming that they start no extra frame.

// File: rtl/spimf_pkg.sv
package spimf_pkg;

   localparam int HDR_BYTES   = 5;
   localparam int RD_DUMMIES  = 4;
   localparam int WORD_MAX    = 8;
   localparam int IDX_W       = 3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR,
      ST_DUMMY,
      ST_FILL,
      ST_DATA,
      ST_DRAIN,
      ST_TAIL,
      ST_GAP,
      ST_DONE
   } spimf_state_e;

   // index of the last byte in a data word for a command code
   function automatic logic [IDX_W-1:0] word_last(input logic [2:0] cmd);
      case (cmd[2:1])
         2'b00:   return 3'd1;
         2'b01:   return 3'd3;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/spimf_byte_shift.sv
module spimf_byte_shift #(
   parameter int HALF = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sclk,
   output logic       mosi
);
   localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

   logic [DIV_W-1:0] div_q;
   logic [2:0]       bit_q;
   logic             busy_q;
   logic [7:0]       tx_q;
   logic [7:0]       rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bit_q  <= '0;
         busy_q <= 1'b0;
         tx_q   <= '0;
         rx_q   <= '0;
         sclk   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy_q && start) begin
            tx_q   <= tx_byte;
            busy_q <= 1'b1;
            div_q  <= '0;
            bit_q  <= '0;
         end else if (busy_q) begin
            if (div_q == DIV_W'(HALF-1)) begin
               div_q <= '0;
               if (!sclk) begin
                  sclk <= 1'b1;
                  rx_q <= {rx_q[6:0], miso};
               end else begin
                  sclk  <= 1'b0;
                  tx_q  <= {tx_q[6:0], 1'b0};
                  bit_q <= bit_q + 3'd1;
                  if (bit_q == 3'd7) begin
                     busy_q <= 1'b0;
                     done   <= 1'b1;
                  end
               end
            end else begin
               div_q <= div_q + DIV_W'(1);
            end
         end
      end
   end

   assign mosi    = tx_q[7];
   assign rx_byte = rx_q;

endmodule

// File: rtl/spimf_word_buf.sv
module spimf_word_buf #(
   parameter int BYTES = 8
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(BYTES)-1:0] widx,
   input  logic [7:0]               wdata,
   input  logic [$clog2(BYTES)-1:0] ridx,
   output logic [7:0]               rdata
);
   localparam int IW = $clog2(BYTES);

   logic [7:0] slot [BYTES];

   for (genvar g = 0; g < BYTES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && widx == IW'(g)) slot[g] <= wdata;
      end
   end

   assign rdata = slot[ridx];

endmodule

// File: rtl/spimf_engine.sv
module spimf_engine
   import spimf_pkg::*;
#(
   parameter int CLK_HZ    = 48_000_000,
   parameter int SCLK_HZ   = 6_000_000,
   parameter int LEN_W     = 8,
   parameter int MAX_BURST = 240,
   parameter int GAP_SCLKS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             desc_valid,
   output logic             desc_ready,
   input  logic [2:0]       desc_cmd,
   input  logic [31:0]      desc_addr,
   input  logic [LEN_W-1:0] desc_len,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic             spi_sclk,
   output logic             spi_cs_n,
   output logic             spi_mosi,
   input  logic             spi_miso
);
   localparam int HALF      = CLK_HZ / (2 * SCLK_HZ);
   localparam int MAX_WORDS = MAX_BURST / WORD_MAX;
   localparam int WCNT_W    = $clog2(MAX_WORDS + 1);
   localparam int GAP_CYC   = 2 * HALF * GAP_SCLKS;
   localparam int GAP_W     = $clog2(GAP_CYC + 1);

   if (HALF < 1) begin : g_bad_rate
      $error("SCLK_HZ must not exceed CLK_HZ/2");
   end
   if (MAX_BURST < WORD_MAX || (MAX_BURST % WORD_MAX) != 0) begin : g_bad_burst
      $error("MAX_BURST must be a nonzero multiple of 8");
   end
   if (LEN_W < 4 || (2 ** LEN_W) <= MAX_BURST) begin : g_bad_len
      $error("LEN_W must hold MAX_BURST");
   end
   if (GAP_SCLKS < 1) begin : g_bad_gap
      $error("GAP_SCLKS must be at least 1");
   end

   spimf_state_e     state_q;
   logic [2:0]       cmd_q;
   logic [31:0]      addr_q;
   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] cnt_q;
   logic [WCNT_W-1:0] words_q;
   logic [GAP_W-1:0] gap_q;
   logic             pend_q;

   logic             launch, sh_done;
   logic [7:0]       tx_byte, sh_rx, buf_rd;
   logic [IDX_W-1:0] rev_idx, buf_ridx, buf_widx;
   logic             buf_we, wr_hs, is_wr;
   logic [LEN_W-1:0] len_div8;
   logic [WCNT_W-1:0] req_words;

   assign is_wr   = cmd_q[0];
   assign rev_idx = last_q - cnt_q;
   assign wr_hs   = wr_valid && wr_ready;

   // words requested by the descriptor being offered
   assign len_div8 = desc_len >> 3;
   always_comb begin
      if (desc_cmd[2:1] != 2'b10 && desc_cmd[2:1] != 2'b11) req_words = WCNT_W'(1);
      else if (len_div8 == '0)                             req_words = WCNT_W'(1);
      else if (32'(len_div8) > MAX_WORDS)                  req_words = WCNT_W'(MAX_WORDS);
      else                                                 req_words = WCNT_W'(len_div8);
   end

   always_comb begin
      case (state_q)
         ST_HDR: begin
            case (cnt_q)
               3'd0:    tx_byte = {5'd0, cmd_q};
               3'd1:    tx_byte = addr_q[31:24];
               3'd2:    tx_byte = addr_q[23:16];
               3'd3:    tx_byte = addr_q[15:8];
               default: tx_byte = addr_q[7:0];
            endcase
         end
         ST_DATA: tx_byte = is_wr ? buf_rd : 8'h00;
         default: tx_byte = 8'h00;
      endcase
   end

   assign launch   = !pend_q && (state_q == ST_HDR || state_q == ST_DUMMY ||
                                 state_q == ST_DATA || state_q == ST_TAIL);
   assign buf_ridx = (state_q == ST_DRAIN) ? cnt_q : rev_idx;
   assign buf_widx = (state_q == ST_FILL) ? cnt_q : rev_idx;
   assign buf_we   = (state_q == ST_FILL) ? wr_hs
                                          : (state_q == ST_DATA && sh_done && !is_wr);

   spimf_byte_shift #(.HALF(HALF)) shift_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (launch),
      .tx_byte (tx_byte),
      .miso    (spi_miso),
      .done    (sh_done),
      .rx_byte (sh_rx),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi)
   );

   spimf_word_buf #(.BYTES(WORD_MAX)) buf_i (
      .clk   (clk),
      .we    (buf_we),
      .widx  (buf_widx),
      .wdata ((state_q == ST_FILL) ? wr_data : sh_rx),
      .ridx  (buf_ridx),
      .rdata (buf_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= '0;
         addr_q  <= '0;
         last_q  <= '0;
         cnt_q   <= '0;
         words_q <= '0;
         gap_q   <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (launch)       pend_q <= 1'b1;
         else if (sh_done) pend_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (desc_valid) begin
               cmd_q   <= desc_cmd;
               addr_q  <= desc_addr;
               last_q  <= word_last(desc_cmd);
               words_q <= req_words;
               cnt_q   <= '0;
               state_q <= ST_HDR;
            end
            ST_HDR: if (pend_q && sh_done) begin
               if (cnt_q == 3'(HDR_BYTES-1)) begin
                  cnt_q   <= '0;
                  state_q <= is_wr ? ST_FILL : ST_DUMMY;
               end else cnt_q <= cnt_q + 3'd1;
            end
            ST_DUMMY: if (pend_q && sh_done) begin
               if (cnt_q == 3'(RD_DUMMIES-1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_DATA;
               end else cnt_q <= cnt_q + 3'd1;
            end
            ST_FILL: if (wr_hs) begin
               if (cnt_q == last_q) begin
                  cnt_q   <= '0;
                  state_q <= ST_DATA;
               end else cnt_q <= cnt_q + 3'd1;
            end
            ST_DATA: if (pend_q && sh_done) begin
               if (cnt_q == last_q) begin
                  cnt_q   <= '0;
                  words_q <= words_q - WCNT_W'(1);
                  if (!is_wr)                    state_q <= ST_DRAIN;
                  else if (words_q == WCNT_W'(1)) state_q <= ST_TAIL;
                  else                           state_q <= ST_FILL;
               end else cnt_q <= cnt_q + 3'd1;
            end
            ST_DRAIN: begin
               if (cnt_q == last_q) begin
                  cnt_q   <= '0;
                  state_q <= (words_q == '0) ? ST_GAP : ST_DATA;
                  gap_q   <= '0;
               end else cnt_q <= cnt_q + 3'd1;
            end
            ST_TAIL: if (pend_q && sh_done) begin
               gap_q   <= '0;
               state_q <= ST_GAP;
            end
            ST_GAP: begin
               if (gap_q == GAP_W'(GAP_CYC-1)) state_q <= ST_DONE;
               else gap_q <= gap_q + GAP_W'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign desc_ready = (state_q == ST_IDLE);
   assign wr_ready   = (state_q == ST_FILL);
   assign rd_valid   = (state_q == ST_DRAIN);
   assign rd_data    = buf_rd;
   assign done       = (state_q == ST_DONE);
   assign spi_cs_n   = (state_q == ST_IDLE || state_q == ST_GAP || state_q == ST_DONE);

endmodule

// File: rtl/spimf_engine_chk.sv
module spimf_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic spi_sclk,
   input logic spi_cs_n,
   input logic spi_mosi,
   input logic done,
   input logic desc_ready,
   input logic rd_valid
);
   // R1: data line moves only in the low half of the clock
   a_r1_mosi_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(spi_mosi) || $fell(spi_mosi)) |-> !spi_sclk);

   // R8: no clock edges outside a frame
   a_r8_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R8: chip select high for more than one cycle between frames
   a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> spi_cs_n);

   // R9: completion only with chip select released
   a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> spi_cs_n);

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: descriptors are taken only outside a frame
   a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ready |-> spi_cs_n);

   // R10: read bytes are handed over inside their frame
   a_r10_rd_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !spi_cs_n);
endmodule

bind spimf_engine spimf_engine_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .spi_sclk   (spi_sclk),
   .spi_cs_n   (spi_cs_n),
   .spi_mosi   (spi_mosi),
   .done       (done),
   .desc_ready (desc_ready),
   .rd_valid   (rd_valid)
);

// File: tb/spimf_engine_tb.sv
`timescale 1ns/1ps
module spimf_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 12_000_000;
   localparam int SCLK_HZ    = 6_000_000;
   localparam int HALF       = CLK_HZ / (2 * SCLK_HZ);
   localparam int GAP_MIN    = 2 * HALF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic desc_valid = 1'b0, desc_ready;
   logic [2:0] desc_cmd = '0;
   logic [31:0] desc_addr = '0;
   logic [7:0] desc_len = '0;
   logic wr_valid = 1'b0, wr_ready;
   logic [7:0] wr_data = '0;
   logic rd_valid, done;
   logic [7:0] rd_data;
   logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

   always #(CLK_PERIOD/2) clk = ~clk;

   spimf_engine #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_cmd(desc_cmd), .desc_addr(desc_addr), .desc_len(desc_len),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   logic [7:0] cap [256];
   logic [7:0] miso_frame [256];
   logic [7:0] wr_src [256];
   logic [7:0] rd_cap [256];
   int cap_cnt = 0, mbit = 0, wr_ptr = 0, wr_len = 0, rd_cnt = 0;
   int done_cnt = 0, done_bad = 0, hi_run = 0, gap_bad = 0, sclk_bad = 0, cs_falls = 0;
   bit prev_cs = 1'b1, seen_frame = 1'b0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // slave model
   always @(posedge spi_sclk) if (!spi_cs_n && cap_cnt < 2048) begin
      cap[cap_cnt >> 3][7 - (cap_cnt & 7)] = spi_mosi;
      cap_cnt++;
   end
   always @(negedge spi_sclk) mbit++;
   assign spi_miso = (mbit < 2048) ? miso_frame[mbit >> 3][7 - (mbit & 7)] : 1'b0;

   // write source with random stalls
   always @(posedge clk) if (wr_valid && wr_ready) wr_ptr++;
   always @(negedge clk) begin
      wr_valid = (wr_ptr < wr_len) && (($urandom % 4) != 0);
      wr_data  = wr_src[wr_ptr & 255];
   end

   // monitors
   always @(negedge clk) if (rst_n) begin
      if (rd_valid && rd_cnt < 256) begin rd_cap[rd_cnt] = rd_data; rd_cnt++; end
      if (done) begin done_cnt++; if (!spi_cs_n) done_bad++; end
      if (spi_cs_n && spi_sclk) sclk_bad++;
      if (spi_cs_n) hi_run++;
      else begin
         if (prev_cs) begin
            cs_falls++;
            if (seen_frame && hi_run < GAP_MIN) gap_bad++;
            seen_frame = 1'b1;
         end
         hi_run = 0;
      end
      prev_cs = spi_cs_n;
   end

   task automatic run_frame(input logic [2:0] cmd, input logic [31:0] addr,
                            input logic [7:0] len, input bit junk);
      int wb, words, n, elen, hdr_bad, dum_bad, dat_bad, rdb, frames0;
      logic [7:0] exp [256];
      bit wr;
      wr = cmd[0];
      wb = (cmd[2:1] == 2'b00) ? 2 : (cmd[2:1] == 2'b01) ? 4 : 8;
      if (wb != 8) words = 1;
      else begin
         words = int'(len) / 8;
         if (words < 1) words = 1;
         if (words > 30) words = 30;
      end
      n = wb * words;
      for (int i = 0; i < 256; i++) begin
         miso_frame[i] = 8'h00;
         wr_src[i] = 8'($urandom);
         exp[i] = 8'h00;
      end
      exp[0] = {5'd0, cmd};
      exp[1] = addr[31:24]; exp[2] = addr[23:16]; exp[3] = addr[15:8]; exp[4] = addr[7:0];
      if (wr) begin
         for (int w = 0; w < words; w++)
            for (int i = 0; i < wb; i++) exp[5 + w*wb + i] = wr_src[w*wb + wb - 1 - i];
         elen = 6 + n;
      end else begin
         for (int j = 0; j < n; j++) miso_frame[9 + j] = 8'($urandom);
         elen = 9 + n;
      end
      cap_cnt = 0; mbit = 0; wr_ptr = 0; wr_len = wr ? n : 0; rd_cnt = 0;
      done_cnt = 0; done_bad = 0; frames0 = cs_falls;
      @(negedge clk);
      desc_valid = 1'b1; desc_cmd = cmd; desc_addr = addr; desc_len = len;
      @(posedge clk);
      @(negedge clk);
      if (junk) begin
         chk(desc_ready == 1'b0, "R9", "desc_ready during frame", int'(desc_ready), 0);
         desc_cmd = ~cmd; desc_addr = ~addr; desc_len = 8'd255;
         repeat (8) @(negedge clk);
      end
      desc_valid = 1'b0;
      while (done_cnt == 0) @(negedge clk);
      repeat (20) @(negedge clk);
      hdr_bad = 0; dum_bad = 0; dat_bad = 0; rdb = 0;
      for (int i = 0; i < elen; i++) begin
         if (cap[i] !== exp[i]) begin
            if (i < 5) hdr_bad++;
            else if (!wr && i < 9) dum_bad++;
            else if (wr && i == 5 + n) dum_bad++;
            else dat_bad++;
         end
      end
      chk(cap_cnt == 8*elen, (wb == 8) ? "R7" : "R6", "frame bits", cap_cnt, 8*elen);
      chk(hdr_bad == 0, "R1", "header byte mismatches", hdr_bad, 0);
      chk(dum_bad == 0, wr ? "R4" : "R3", "dummy byte mismatches", dum_bad, 0);
      chk(dat_bad == 0, "R5", "write/idle data mismatches", dat_bad, 0);
      if (wr) chk(wr_ptr == n, "R10", "write bytes consumed", wr_ptr, n);
      else begin
         chk(rd_cnt == n, "R10", "read bytes delivered", rd_cnt, n);
         for (int w = 0; w < words; w++)
            for (int k = 0; k < wb; k++)
               if (rd_cap[w*wb + k] !== miso_frame[9 + w*wb + wb - 1 - k]) rdb++;
         chk(rdb == 0, "R5", "read byte order mismatches", rdb, 0);
      end
      chk(done_cnt == 1 && done_bad == 0, "R9", "done pulses", done_cnt, 1);
      chk(cs_falls - frames0 == 1, "R9", "frames started", cs_falls - frames0, 1);
   endtask

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R11", "cs_n after reset", int'(spi_cs_n), 1);
      chk(spi_sclk == 1'b0, "R11", "sclk after reset", int'(spi_sclk), 0);
      chk(desc_ready == 1'b1 && !done && !rd_valid && !wr_ready, "R11", "handshake outputs after reset",
          int'({desc_ready, done, rd_valid, wr_ready}), 8);
      // R2: each code in turn, R6 length ignored on short commands
      run_frame(3'd0, 32'h6003_0002, 8'd200, 1'b1);
      run_frame(3'd1, 32'h6003_0104, 8'd77, 1'b0);
      run_frame(3'd2, 32'h6003_0004, 8'd0, 1'b0);
      run_frame(3'd3, 32'h5000_0100, 8'd16, 1'b0);
      run_frame(3'd4, 32'h6003_0008, 8'd8, 1'b0);
      run_frame(3'd5, 32'h5000_0000, 8'd240, 1'b1);
      // R7 corner counts
      run_frame(3'd5, 32'h5000_0200, 8'd21, 1'b0);
      run_frame(3'd4, 32'h6000_0000, 8'd250, 1'b0);
      run_frame(3'd5, 32'h5000_0300, 8'd3, 1'b0);
      for (int r = 0; r < 12; r++)
         run_frame(3'($urandom % 6), $urandom, 8'($urandom), r[0]);
      chk(gap_bad == 0, "R8", "short chip-select gaps", gap_bad, 0);
      chk(sclk_bad == 0, "R8", "sclk high with cs_n high", sclk_bad, 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule